// File: doc/BRIEF.md
# SIMD Floating-Point Max/Min Unit

This block compares two 128-bit vector operands lane by lane and returns, for each lane, the larger or the smaller value under a fixed selection order. A two-bit lane-mode input chooses how the operands are split: one double-precision value in the low half, two double-precision values, or four single-precision values. A single select bit picks maximum or minimum for every lane of the operation.

The selection does not use a generic IEEE comparison. Signalling NaNs win first, operand A before operand B, and come out quieted. Quiet NaNs are passed over in favour of the other operand. Infinities are then examined, A before B. The remaining operands are ordered from their raw sign, exponent and fraction fields, which places negative zero below positive zero. The datapath is combinational and ends in a single register stage. A sticky flag records every signalling NaN seen in an active lane until software pulses a clear input.

Top module: `fpmm_unit`

## Requirements
- R1: `mode_i` 2'b00 is scalar double, with the lane in result bits 63:0. 2'b01 is two doubles, with lane 0 in bits 63:0 and lane 1 in bits 127:64. 2'b10 and 2'b11 are four singles, with lane k in bits 32k+31:32k. Each lane uses IEEE-754 layout: sign in the top bit, then the biased exponent, then the fraction.
- R2: If operand A of a lane is a signalling NaN (exponent all ones, fraction nonzero, top fraction bit clear), the lane result is A with its top fraction bit set (bit 51 for doubles, bit 22 for singles). The invalid flag is set.
- R3: If A is not a signalling NaN and B is one, the lane result is B with its top fraction bit set. The invalid flag is set.
- R4: With no signalling NaN in the lane, a quiet NaN in B gives A. A quiet NaN in A alone gives B. Two quiet NaNs therefore give A. None of these cases sets the flag.
- R5: With no NaN in the lane, infinities are examined in A first and then in B. For max, a positive infinity is returned and a negative infinity yields the other operand. For min, a negative infinity is returned and a positive infinity yields the other operand.
- R6: For finite operands of different sign, the negative operand is the smaller one, so -0 is below +0.
- R7: For finite operands of equal sign, the exponent and fraction fields are compared as one unsigned magnitude, and the outcome is inverted when both operands are negative. Max returns B when A is below B and A otherwise. Min returns A when A is below B and B otherwise.
- R8: In scalar mode, result bits 127:64 carry `prev_hi_i` when parameter KEEP_UPPER is 1 and are zero when it is 0. Signalling NaNs in the upper operand halves are ignored.
- R9: `out_valid_o` equals `in_valid_i` of the previous clock. The result for an accepted operation appears one clock after `in_valid_i`, and `result_o` holds its value on cycles without `in_valid_i`.
- R10: `invalid_o` is the OR of signalling-NaN detections over the active lanes of accepted operations. It stays set until `clr_flag_i` is pulsed. A detection in the same cycle as a clear leaves the flag set.
- R11: Synchronous reset clears `out_valid_o`, `invalid_o` and `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| op_max_i | input | 1 | 1 selects maximum, 0 selects minimum |
| mode_i | input | 2 | Lane mode (R1) |
| opa_i | input | 128 | Operand A |
| opb_i | input | 128 | Operand B |
| prev_hi_i | input | 64 | Prior destination upper half for scalar mode |
| clr_flag_i | input | 1 | Clears the sticky invalid flag |
| out_valid_o | output | 1 | Result strobe, one clock after `in_valid_i` |
| result_o | output | 128 | Registered lane results |
| invalid_o | output | 1 | Sticky signalling-NaN flag |

## Verification
The assertions assume that `mode_i`, the operands and `prev_hi_i` are stable and known whenever `in_valid_i` is high, and that `clr_flag_i` is a level sampled only at the clock edge. The bench drives every input on the falling edge, so these values are settled long before the rising edge that captures them. It pulses the clear together with each table operation, which makes the flag's expected value depend on that operation alone. The separate directed steps exercise flag retention and the idle-hold behaviour.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    // lane-mode encodings
    typedef enum logic [1:0] {
        LM_SCALAR_D = 2'b00,
        LM_DUAL_D   = 2'b01,
        LM_QUAD_S   = 2'b10,
        LM_QUAD_S2  = 2'b11
    } lane_mode_e;

    localparam int D_EXP  = 11;
    localparam int D_FRAC = 52;
    localparam int D_W    = 1 + D_EXP + D_FRAC;
    localparam int S_EXP  = 8;
    localparam int S_FRAC = 23;
    localparam int S_W    = 1 + S_EXP + S_FRAC;

    // operand classification carried through a lane
    typedef struct packed {
        logic neg;
        logic is_nan;
        logic is_snan;
        logic is_inf;
    } fp_class_t;

    // which rule picked the lane result
    typedef enum logic [2:0] {
        PICK_SNAN_A,
        PICK_SNAN_B,
        PICK_QNAN,
        PICK_INF_A,
        PICK_INF_B,
        PICK_ORDER
    } pick_rule_e;

endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane
    import fpmm_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         max_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         snan_o
);

    localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

    fp_class_t  ca, cb;
    pick_rule_e rule;
    logic       a_below;

    function automatic fp_class_t classify(input logic [W-1:0] v);
        fp_class_t c;
        logic exp_ones, frac_nz;
        exp_ones  = &v[W-2:FRAC_W];
        frac_nz   = |v[FRAC_W-1:0];
        c.neg     = v[W-1];
        c.is_nan  = exp_ones && frac_nz;
        c.is_snan = exp_ones && frac_nz && !v[FRAC_W-1];
        c.is_inf  = exp_ones && !frac_nz;
        return c;
    endfunction

    always_comb begin
        ca = classify(a_i);
        cb = classify(b_i);

        // raw field ordering: sign, then magnitude inverted for negatives
        if (ca.neg != cb.neg)
            a_below = ca.neg;
        else if (ca.neg)
            a_below = a_i[W-2:0] > b_i[W-2:0];
        else
            a_below = a_i[W-2:0] < b_i[W-2:0];

        if (ca.is_snan)                 rule = PICK_SNAN_A;
        else if (cb.is_snan)            rule = PICK_SNAN_B;
        else if (ca.is_nan || cb.is_nan) rule = PICK_QNAN;
        else if (ca.is_inf)             rule = PICK_INF_A;
        else if (cb.is_inf)             rule = PICK_INF_B;
        else                            rule = PICK_ORDER;

        unique case (rule)
            PICK_SNAN_A: res_o = a_i | QBIT;
            PICK_SNAN_B: res_o = b_i | QBIT;
            PICK_QNAN:   res_o = cb.is_nan ? a_i : b_i;
            PICK_INF_A:  res_o = (ca.neg == max_i) ? b_i : a_i;
            PICK_INF_B:  res_o = (cb.neg == max_i) ? a_i : b_i;
            default:     res_o = (a_below == max_i) ? b_i : a_i;
        endcase

        snan_o = ca.is_snan || cb.is_snan;
    end

    // R2/R3: a signalling input never leaves the lane unquieted
    always_comb begin
        a_r2_quieted: assert (!snan_o || (res_o[FRAC_W-1] && &res_o[W-2:FRAC_W]))
            else $error("signalling NaN left lane unquieted");
        a_r4_source: assert (res_o == a_i || res_o == b_i ||
                             res_o == (a_i | QBIT) || res_o == (b_i | QBIT))
            else $error("lane result not drawn from an operand");
    end

endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
    import fpmm_pkg::*;
#(
    parameter int VEC_W      = 128,
    parameter bit KEEP_UPPER = 1'b1,
    localparam int NUM_D     = VEC_W / D_W,
    localparam int NUM_S     = VEC_W / S_W,
    localparam int HI_W      = VEC_W - D_W
) (
    input  lane_mode_e       mode_i,
    input  logic [VEC_W-1:0] d_res_i,
    input  logic [NUM_D-1:0] d_snan_i,
    input  logic [VEC_W-1:0] s_res_i,
    input  logic [NUM_S-1:0] s_snan_i,
    input  logic [HI_W-1:0]  prev_hi_i,
    output logic [VEC_W-1:0] res_o,
    output logic             snan_o
);

    logic [HI_W-1:0] scalar_hi;

    generate
        if (KEEP_UPPER) begin : g_keep
            assign scalar_hi = prev_hi_i;
        end else begin : g_zero
            assign scalar_hi = '0;
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            LM_SCALAR_D: begin
                res_o  = {scalar_hi, d_res_i[D_W-1:0]};
                snan_o = d_snan_i[0];
            end
            LM_DUAL_D: begin
                res_o  = d_res_i;
                snan_o = |d_snan_i;
            end
            default: begin
                res_o  = s_res_i;
                snan_o = |s_snan_i;
            end
        endcase
    end

    // R1: single-lane mode draws its low half from double lane 0
    always_comb begin
        a_r1_scalar_low: assert (mode_i != LM_SCALAR_D || res_o[D_W-1:0] == d_res_i[D_W-1:0])
            else $error("scalar low half mismatch");
    end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int VEC_W      = 128,
    parameter bit KEEP_UPPER = 1'b1,
    localparam int NUM_D     = VEC_W / D_W,
    localparam int NUM_S     = VEC_W / S_W,
    localparam int HI_W      = VEC_W - D_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic             op_max_i,
    input  logic [1:0]       mode_i,
    input  logic [VEC_W-1:0] opa_i,
    input  logic [VEC_W-1:0] opb_i,
    input  logic [HI_W-1:0]  prev_hi_i,
    input  logic             clr_flag_i,
    output logic             out_valid_o,
    output logic [VEC_W-1:0] result_o,
    output logic             invalid_o
);

    logic [VEC_W-1:0] d_res, s_res, nxt_res;
    logic [NUM_D-1:0] d_snan;
    logic [NUM_S-1:0] s_snan;
    logic             nxt_snan;

    generate
        for (genvar d = 0; d < NUM_D; d++) begin : g_dbl
            fpmm_lane #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_lane (
                .max_i  (op_max_i),
                .a_i    (opa_i[d*D_W +: D_W]),
                .b_i    (opb_i[d*D_W +: D_W]),
                .res_o  (d_res[d*D_W +: D_W]),
                .snan_o (d_snan[d])
            );
        end
        for (genvar s = 0; s < NUM_S; s++) begin : g_sgl
            fpmm_lane #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_lane (
                .max_i  (op_max_i),
                .a_i    (opa_i[s*S_W +: S_W]),
                .b_i    (opb_i[s*S_W +: S_W]),
                .res_o  (s_res[s*S_W +: S_W]),
                .snan_o (s_snan[s])
            );
        end
    endgenerate

    fpmm_select #(.VEC_W(VEC_W), .KEEP_UPPER(KEEP_UPPER)) u_sel (
        .mode_i    (lane_mode_e'(mode_i)),
        .d_res_i   (d_res),
        .d_snan_i  (d_snan),
        .s_res_i   (s_res),
        .s_snan_i  (s_snan),
        .prev_hi_i (prev_hi_i),
        .res_o     (nxt_res),
        .snan_o    (nxt_snan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            invalid_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i)
                result_o <= nxt_res;
            invalid_o <= (invalid_o && !clr_flag_i) || (in_valid_i && nxt_snan);
        end
    end

    a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> $stable(result_o));
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        invalid_o && !clr_flag_i |=> invalid_o);
    a_r10_set: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && nxt_snan |=> invalid_o);
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr_flag_i && !(in_valid_i && nxt_snan) |=> !invalid_o);
    a_r8_upper: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && mode_i == LM_SCALAR_D |=>
            result_o[VEC_W-1:D_W] == ((KEEP_UPPER != 0) ? $past(prev_hi_i) : '0));

endmodule

// File: tb/tb_fpmm_unit.sv
module tb_fpmm_unit;

    typedef struct packed {
        logic [1:0]   mode;
        logic         mx;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] r;
        logic         f;
    } vec_t;

    // doubles
    localparam logic [63:0] D1   = 64'h3FF0000000000000;
    localparam logic [63:0] D2   = 64'h4000000000000000;
    localparam logic [63:0] DM1  = 64'hBFF0000000000000;
    localparam logic [63:0] DM2  = 64'hC000000000000000;
    localparam logic [63:0] DPI  = 64'h7FF0000000000000;
    localparam logic [63:0] DNI  = 64'hFFF0000000000000;
    localparam logic [63:0] DQN  = 64'h7FF8000000000000;
    localparam logic [63:0] DPZ  = 64'h0000000000000000;
    localparam logic [63:0] DNZ  = 64'h8000000000000000;
    // singles
    localparam logic [31:0] S1   = 32'h3F800000;
    localparam logic [31:0] S2   = 32'h40000000;
    localparam logic [31:0] SM1  = 32'hBF800000;
    localparam logic [31:0] SM2  = 32'hC0000000;
    localparam logic [31:0] SPI  = 32'h7F800000;
    localparam logic [31:0] SNI  = 32'hFF800000;
    localparam logic [31:0] SQN  = 32'h7FC00000;
    localparam logic [31:0] SNZ  = 32'h80000000;
    localparam logic [31:0] SPZ  = 32'h00000000;

    localparam logic [63:0] HI_PAT = 64'h0123456789ABCDEF;
    localparam int NV = 16;

    localparam vec_t VT [NV] = '{
        // R7 dual max / min, positives
        '{2'b01, 1'b1, {D2, D1}, {D1, D2}, {D2, D2}, 1'b0},
        '{2'b01, 1'b0, {D2, D1}, {D1, D2}, {D1, D1}, 1'b0},
        // R7 negatives invert magnitude order
        '{2'b01, 1'b1, {DM1, DM2}, {DM2, DM1}, {DM1, DM1}, 1'b0},
        // R6 signed zeros
        '{2'b01, 1'b0, {DNZ, DPZ}, {DPZ, DNZ}, {DNZ, DNZ}, 1'b0},
        '{2'b01, 1'b1, {DNZ, DPZ}, {DPZ, DNZ}, {DPZ, DPZ}, 1'b0},
        // R2 lane1 A signalling, R3 lane0 B signalling
        '{2'b01, 1'b1, {64'h7FF0000000000001, D1}, {D1, 64'h7FF0000000000005},
          {64'h7FF8000000000001, 64'h7FF8000000000005}, 1'b1},
        // R2 both signalling -> A; R3 A quiet, B signalling negative
        '{2'b01, 1'b0, {64'h7FF0000000000001, DQN}, {64'h7FF0000000000002, 64'hFFF0000000000003},
          {64'h7FF8000000000001, 64'hFFF8000000000003}, 1'b1},
        // R4 single quiet NaN
        '{2'b01, 1'b1, {DQN, D1}, {D2, DQN}, {D2, D1}, 1'b0},
        // R4 two quiet NaNs -> A; R5 negative inf in max
        '{2'b01, 1'b1, {DQN, DNI}, {64'hFFF8000000000001, D2}, {DQN, D2}, 1'b0},
        // R5 min with infinities
        '{2'b01, 1'b0, {DPI, DM1}, {DM1, DNI}, {DM1, DNI}, 1'b0},
        // R5 max: both infinities / B infinite
        '{2'b01, 1'b1, {DPI, D2}, {DNI, DPI}, {DPI, DPI}, 1'b0},
        // R1 quad max: order, signs, zeros, signalling A
        '{2'b10, 1'b1, {S1, SM1, SNZ, 32'h7F800001}, {S2, SM2, SPZ, S1},
          {S2, SM1, SPZ, 32'h7FC00001}, 1'b1},
        // R1 quad min: negative inf, quiet NaN in A
        '{2'b10, 1'b0, {S1, SM1, SNI, SQN}, {S2, SM2, S1, SM2},
          {S1, SM2, SNI, SM2}, 1'b0},
        // R1 mode 11 also quad singles; R3 B signalling in lane 0
        '{2'b11, 1'b1, {SPI, S1, S2, SM1}, {S2, SQN, S1, 32'h7F800002},
          {SPI, S1, S2, 32'h7FC00002}, 1'b1},
        // R8 scalar: signalling NaN in the unused upper half is ignored
        '{2'b00, 1'b1, {64'h7FF0000000000001, D1}, {64'h7FF0000000000007, D2},
          {HI_PAT, D2}, 1'b0},
        // R8 scalar min with signalling A in lane 0 (R2)
        '{2'b00, 1'b0, {D1, 64'h7FF0000000000009}, {D2, D1},
          {HI_PAT, 64'h7FF8000000000009}, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_max = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [63:0]  prev_hi = HI_PAT;
    logic         clr = 1'b0;
    logic         ov, ovz, inv, invz;
    logic [127:0] res, resz;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fpmm_unit dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .op_max_i(op_max),
        .mode_i(mode), .opa_i(opa), .opb_i(opb), .prev_hi_i(prev_hi),
        .clr_flag_i(clr), .out_valid_o(ov), .result_o(res), .invalid_o(inv)
    );

    fpmm_unit #(.KEEP_UPPER(1'b0)) dut_z (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .op_max_i(op_max),
        .mode_i(mode), .opa_i(opa), .opb_i(opb), .prev_hi_i(prev_hi),
        .clr_flag_i(clr), .out_valid_o(ovz), .result_o(resz), .invalid_o(invz)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        logic [127:0] rz;
        v = VT[i];
        @(negedge clk);
        mode = v.mode; op_max = v.mx; opa = v.a; opb = v.b;
        in_valid = 1'b1; clr = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
        rz = (v.mode == 2'b00) ? {64'h0, v.r[63:0]} : v.r;
        chk($sformatf("R9 valid vec%0d", i), {127'b0, ov}, 128'd1);
        chk($sformatf("R1-R8 result vec%0d", i), res, v.r);
        chk($sformatf("R8 zero-upper result vec%0d", i), resz, rz);
        chk($sformatf("R10 flag vec%0d", i), {127'b0, inv}, {127'b0, v.f});
    endtask

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid after reset", {127'b0, ov}, 128'd0);
        chk("R11 result after reset", res, 128'd0);
        chk("R11 flag after reset", {127'b0, inv}, 128'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: idle cycle with new operands keeps the result, drops valid
        held = res;
        @(negedge clk);
        mode = 2'b01; op_max = 1'b1; opa = {D2, D2}; opb = {DM1, DM1};
        @(negedge clk);
        chk("R9 valid low when idle", {127'b0, ov}, 128'd0);
        chk("R9 result held when idle", res, held);

        // R10: flag set by a signalling operation, then retained
        @(negedge clk);
        mode = 2'b10; op_max = 1'b0; opa = {S1, S1, S1, 32'h7F800003}; opb = {S2, S2, S2, S2};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 quad min signalling A", res, {S1, S1, S1, 32'h7FC00003});
        chk("R10 flag set", {127'b0, inv}, 128'd1);
        @(negedge clk);
        mode = 2'b01; opa = {D1, D1}; opb = {D2, D2}; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 flag held across clean op", {127'b0, inv}, 128'd1);
        chk("R7 clean op result", res, {D1, D1});
        @(negedge clk);
        chk("R10 flag held while idle", {127'b0, inv}, 128'd1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R10 flag cleared", {127'b0, inv}, 128'd0);

        // R10: dual mode ignores a single-format signalling pattern in lane bits
        @(negedge clk);
        mode = 2'b01; op_max = 1'b1;
        opa = {D1, 32'h3FF00000, 32'h7F800001};
        opb = {D2, D1};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 dual lanes use double layout", res, {D2, 64'h3FF000007F800001});
        chk("R10 no flag from double lanes", {127'b0, inv}, 128'd0);

        // R11: reset mid-run clears result and flag
        @(negedge clk);
        opa = {D1, 64'h7FF0000000000001}; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 flag before reset", {127'b0, inv}, 128'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 result cleared", res, 128'd0);
        chk("R11 flag cleared", {127'b0, inv}, 128'd0);
        chk("R11 valid cleared", {127'b0, ov}, 128'd0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule